// File: doc/BRIEF.md
# Per-Bank Weighted Two-Source Arbiter

This block chooses, each cycle, between a host-processor requester and an I/O-complex requester that both want to issue a DRAM command. Each requester presents a valid bit and a 3-bit bank index. A separate enable input for each source decides whether that source may reach DRAM at all. When both sources want the same bank, the host normally wins. Each bank keeps its own small count of host grants made since that bank last served the I/O source. Once that count reaches a programmable threshold, the I/O source is forced through.

The threshold comes from the two low bits of a 4-bit weight input. The result is a registered, one-hot, two-bit grant. A requester holds its valid until it sees its grant. During the cycle its grant is shown, its valid is not considered, so an accepted request is never served twice.

Top module: `wrr_arb`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the grant is 00 and every bank counter is zero.
- R2: The grant has two bits: bit 0 is the host grant and bit 1 is the I/O grant. At most one bit is set. The grant appears one clock after the inputs that decide it, and it is 00 when no source is eligible.
- R3: A source whose enable input is 0 is treated as not requesting, whatever its valid bit shows.
- R4: The host is granted when it is the only eligible source, or when both are eligible but target different banks. The counter of the host's bank then increments.
- R5: The I/O source is granted when it is the only eligible source. Every I/O grant clears the counter of the bank it targets.
- R6: With weight low bits 00, a same-bank contention is granted to the I/O source once that bank's counter is at least 1. Weight bits 3:2 have no effect.
- R7: With weight low bits 01, a same-bank contention goes to the I/O source once the bank's counter is at least 2; below that, the host wins.
- R8: With weight low bits 11, a same-bank contention goes to the I/O source once the bank's counter is at least 3; below that, the host wins.
- R9: The reserved weight code 10 behaves exactly like code 00.
- R10: Each bank counter saturates at 3. Further host grants to that bank leave it at 3.
- R11: A source granted in one cycle is not eligible in the next cycle, so no source is granted on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_vld | input | 1 | Host request valid |
| host_bank | input | 3 | Bank targeted by the host request |
| host_en | input | 1 | Allows host transfers to reach DRAM |
| io_vld | input | 1 | I/O-complex request valid |
| io_bank | input | 3 | Bank targeted by the I/O request |
| io_en | input | 1 | Allows I/O transfers to reach DRAM |
| weight | input | 4 | Weight field; only bits 1:0 select the host-grant threshold |
| gnt | output | 2 | One-hot grant: bit 0 host, bit 1 I/O |

## Verification
Every grant decision is due exactly one clock after the inputs that cause it, because the grant comes from a single register. The counter change made by that grant first affects the decision for inputs applied one cycle later. The bench drives inputs on the falling edge and reads the grant on the next falling edge. It predicts the grant from a model of the eight counters and the previous grant, and it updates that model in the same step, so each comparison falls in the cycle the result is due. Directed sequences separate contentions with idle cycles, which keeps the one-cycle ineligibility after a grant from hiding the threshold behaviour.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;

    // low two bits of the weight field
    typedef enum logic [1:0] {
        WGT_ONE   = 2'b00,
        WGT_TWO   = 2'b01,
        WGT_RSVD  = 2'b10,
        WGT_THREE = 2'b11
    } wgt_code_e;

    localparam int GNT_W    = 2;
    localparam int HOST_IDX = 0;
    localparam int IO_IDX   = 1;

endpackage

// File: rtl/wrr_thresh_dec.sv
module wrr_thresh_dec
    import wrr_arb_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [1:0]       code,
    output logic [CNT_W-1:0] thr
);

    always_comb begin
        case (wgt_code_e'(code))
            WGT_TWO:   thr = CNT_W'(2);
            WGT_THREE: thr = CNT_W'(3);
            default:   thr = CNT_W'(1);   // 00 and reserved 10
        endcase
    end

endmodule

// File: rtl/wrr_cnt_sel.sv
module wrr_cnt_sel #(
    parameter int NUM_BANKS = 8,
    parameter int CNT_W     = 2,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS-1:0][CNT_W-1:0] cnt,
    input  logic [BANK_W-1:0]               sel,
    output logic [CNT_W-1:0]                val
);

    logic [NUM_BANKS-1:0][CNT_W-1:0] term;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_term
        assign term[b] = (sel == BANK_W'(b)) ? cnt[b] : '0;
    end

    always_comb begin
        val = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            val = val | term[b];
        end
    end

endmodule

// File: rtl/wrr_pick.sv
module wrr_pick (
    input  logic host_req,
    input  logic io_req,
    input  logic same_bank,
    input  logic io_due,
    output logic pick_host,
    output logic pick_io
);

    always_comb begin
        pick_io   = io_req && (!host_req || (same_bank && io_due));
        pick_host = host_req && !pick_io;
    end

endmodule

// File: rtl/wrr_arb.sv
module wrr_arb
    import wrr_arb_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int CNT_W     = 2,
    parameter int WGT_W     = 4,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_vld,
    input  logic [BANK_W-1:0] host_bank,
    input  logic              host_en,
    input  logic              io_vld,
    input  logic [BANK_W-1:0] io_bank,
    input  logic              io_en,
    input  logic [WGT_W-1:0]  weight,
    output logic [GNT_W-1:0]  gnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [NUM_BANKS-1:0][CNT_W-1:0] cnt;
        logic [GNT_W-1:0]                gnt;
    } state_t;

    state_t st_d, st_q;

    logic             host_req, io_req, same_bank, io_due;
    logic             pick_host, pick_io;
    logic [CNT_W-1:0] thr, io_cnt, host_cnt;
    logic             wgt_unused;

    assign wgt_unused = ^weight[WGT_W-1:2];

    // a source shown its grant this cycle is not eligible again yet
    assign host_req  = host_vld && host_en && !st_q.gnt[HOST_IDX];
    assign io_req    = io_vld   && io_en   && !st_q.gnt[IO_IDX];
    assign same_bank = (host_bank == io_bank);
    assign io_due    = (io_cnt >= thr);

    wrr_thresh_dec #(.CNT_W(CNT_W)) u_dec (
        .code (weight[1:0]),
        .thr  (thr)
    );

    wrr_cnt_sel #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .BANK_W(BANK_W)) u_sel_io (
        .cnt (st_q.cnt),
        .sel (io_bank),
        .val (io_cnt)
    );

    wrr_cnt_sel #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .BANK_W(BANK_W)) u_sel_host (
        .cnt (st_q.cnt),
        .sel (host_bank),
        .val (host_cnt)
    );

    wrr_pick u_pick (
        .host_req  (host_req),
        .io_req    (io_req),
        .same_bank (same_bank),
        .io_due    (io_due),
        .pick_host (pick_host),
        .pick_io   (pick_io)
    );

    always_comb begin
        st_d = st_q;
        st_d.gnt = '0;
        st_d.gnt[HOST_IDX] = pick_host;
        st_d.gnt[IO_IDX]   = pick_io;
        if (pick_io) begin
            st_d.cnt[io_bank] = '0;
        end else if (pick_host && host_cnt != CNT_MAX) begin
            st_d.cnt[host_bank] = host_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt = st_q.gnt;

endmodule

// File: rtl/wrr_arb_chk.sv
module wrr_arb_chk #(
    parameter int BANK_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_vld,
    input logic [BANK_W-1:0] host_bank,
    input logic              host_en,
    input logic              io_vld,
    input logic [BANK_W-1:0] io_bank,
    input logic              io_en,
    input logic [1:0]        gnt
);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> gnt == 2'b00);

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r3_host_gated: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[0] |-> $past(host_vld && host_en));

    a_r3_io_gated: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[1] |-> $past(io_vld && io_en));

    a_r4_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (host_vld && host_en && !gnt[0] &&
         (!(io_vld && io_en && !gnt[1]) || host_bank != io_bank)) |=> gnt[0]);

    a_r5_io_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (io_vld && io_en && !gnt[1] && !(host_vld && host_en && !gnt[0])) |=> gnt[1]);

    a_r11_host_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[0] |=> !gnt[0]);

    a_r11_io_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[1] |=> !gnt[1]);

endmodule

bind wrr_arb wrr_arb_chk #(.BANK_W(BANK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_vld  (host_vld),
    .host_bank (host_bank),
    .host_en   (host_en),
    .io_vld    (io_vld),
    .io_bank   (io_bank),
    .io_en     (io_en),
    .gnt       (gnt)
);

// File: tb/wrr_arb_bench.sv
module wrr_arb_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_vld = 1'b0, io_vld = 1'b0;
    logic [2:0] host_bank = '0, io_bank = '0;
    logic       host_en = 1'b0, io_en = 1'b0;
    logic [3:0] weight = '0;
    logic [1:0] gnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int         m_cnt [8];
    logic [1:0] m_prev;

    always #2ns clk = ~clk;   // 250 MHz

    wrr_arb u_wrr_arb (
        .clk (clk), .rst_n (rst_n),
        .host_vld (host_vld), .host_bank (host_bank), .host_en (host_en),
        .io_vld (io_vld), .io_bank (io_bank), .io_en (io_en),
        .weight (weight), .gnt (gnt)
    );

    task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    function automatic int thr_of(input logic [3:0] w);
        case (w[1:0])
            2'b01:   return 2;
            2'b11:   return 3;
            default: return 1;
        endcase
    endfunction

    // expected grant from the model, which it then advances
    function automatic logic [1:0] predict(input logic hv, input int hb, input logic iv, input int ib,
                                           input logic he, input logic ie, input logic [3:0] w,
                                           output string tag);
        logic hr, ir;
        logic [1:0] e;
        hr = hv && he && !m_prev[0];
        ir = iv && ie && !m_prev[1];
        if ((hv && m_prev[0]) || (iv && m_prev[1]))  tag = "R11";
        else if ((hv && !he) || (iv && !ie))         tag = "R3";
        else if (hr && ir && hb == ib) begin
            case (w[1:0])
                2'b00:   tag = "R6";
                2'b01:   tag = "R7";
                2'b11:   tag = "R8";
                default: tag = "R9";
            endcase
        end
        else if (ir)                                 tag = "R5";
        else if (hr)                                 tag = "R4";
        else                                         tag = "R2";
        if (ir && (!hr || (hb == ib && m_cnt[ib] >= thr_of(w)))) begin
            e = 2'b10;
            m_cnt[ib] = 0;
        end else if (hr) begin
            e = 2'b01;
            if (m_cnt[hb] < 3) m_cnt[hb]++;
        end else begin
            e = 2'b00;
        end
        m_prev = e;
        return e;
    endfunction

    task automatic step(input logic hv, input int hb, input logic iv, input int ib,
                        input logic he, input logic ie, input logic [3:0] w, input string force_tag);
        logic [1:0] e;
        string tag;
        host_vld = hv; host_bank = 3'(hb); io_vld = iv; io_bank = 3'(ib);
        host_en = he; io_en = ie; weight = w;
        e = predict(hv, hb, iv, ib, he, ie, w, tag);
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        check(tag, gnt, e);
    endtask

    task automatic idle();
        step(1'b0, 0, 1'b0, 0, 1'b1, 1'b1, 4'b0000, "R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        foreach (m_cnt[i]) m_cnt[i] = 0;
        m_prev = 2'b00;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", gnt, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", gnt, 2'b00);

        // R6: threshold 1, upper weight bits set and ignored
        step(1, 2, 1, 2, 1, 1, 4'b0100, "R6");   // host, cnt=1
        idle();
        step(1, 2, 1, 2, 1, 1, 4'b1100, "R6");   // io
        idle();
        // R7: threshold 2
        step(1, 3, 0, 0, 1, 1, 4'b0001, "R4");
        idle();
        step(1, 3, 1, 3, 1, 1, 4'b0001, "R7");   // host, cnt=2
        idle();
        step(1, 3, 1, 3, 1, 1, 4'b0001, "R7");   // io
        idle();
        // R8: threshold 3
        step(1, 4, 0, 0, 1, 1, 4'b0011, "R4");
        idle();
        step(1, 4, 0, 0, 1, 1, 4'b0011, "R4");
        idle();
        step(1, 4, 1, 4, 1, 1, 4'b0011, "R8");   // host, cnt=3
        idle();
        step(1, 4, 1, 4, 1, 1, 4'b0011, "R8");   // io
        idle();
        // R9: reserved code acts as threshold 1
        step(1, 6, 0, 0, 1, 1, 4'b0010, "R4");
        idle();
        step(1, 6, 1, 6, 1, 1, 4'b0010, "R9");   // io
        idle();
        // R10: five host grants must saturate, not wrap
        for (int k = 0; k < 5; k++) begin
            step(1, 1, 0, 0, 1, 1, 4'b0011, "R10");
            idle();
        end
        step(1, 1, 1, 1, 1, 1, 4'b0011, "R10");  // io
        idle();
        // R5: the io grant cleared bank 1, so host wins at threshold 1
        step(1, 1, 1, 1, 1, 1, 4'b0000, "R5");
        idle();
        step(0, 0, 1, 5, 1, 1, 4'b0000, "R5");   // io alone
        idle();
        // R4: different banks, host wins
        step(1, 0, 1, 7, 1, 1, 4'b0000, "R4");
        // R11: host still valid in its grant cycle is ignored
        step(1, 0, 0, 0, 1, 1, 4'b0000, "R11");
        idle();
        // R3: disabled sources
        step(1, 0, 0, 0, 0, 1, 4'b0000, "R3");
        step(0, 0, 1, 2, 1, 0, 4'b0000, "R3");
        step(1, 5, 1, 5, 0, 1, 4'b0000, "R3");   // io only eligible

        for (int n = 0; n < 4000; n++) begin
            logic hv, iv, he, ie;
            int hb, ib;
            logic [3:0] w;
            hv = ($urandom % 4) != 0;
            iv = ($urandom % 4) != 0;
            he = ($urandom % 8) != 0;
            ie = ($urandom % 8) != 0;
            hb = $urandom % 3;
            ib = $urandom % 3;
            w  = 4'($urandom);
            step(hv, hb, iv, ib, he, ie, w, "");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule